// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the sending half of a debug serial port. One byte of storage sits in front of a frame shifter, so software can post the next byte while the current one is still on the wire. A posted byte moves into the shifter as soon as the shifter is free. It leaves as a frame: a low start bit, the eight data bits with the least significant first, an optional parity bit and a high stop bit. Each bit lasts one period of an external baud tick.

Two flags tell the writer what to do. `hold_ready` means the waiting slot can accept a byte. `all_sent` means every accepted byte has left the line, stop bit included. The parity bit can be left out, or set to odd, even, always 0 or always 1. Dropping the enable empties the block at once and parks the line high.

Top module: `dbg_uart_tx`

## Requirements
- R1: `ser_out` is 1 whenever no frame is being sent, while `tx_en` is 0, and during reset.
- R2: A frame is sent in this order: start bit 0, data bits 0 to 7 (least significant first), the parity bit if enabled, then stop bit 1. Each bit lasts exactly one baud-tick period, and the first bit begins on a baud tick.
- R3: `par_mode` uses these codes: 0 = no parity bit, 1 = odd (data plus parity hold an odd count of ones), 2 = even, 3 = parity bit always 0, 4 = parity bit always 1. Codes 5 to 7 act as 0. The mode is sampled when the byte enters the shifter.
- R4: While `tx_en` is 1 and the waiting slot is empty, `hold_ready` is 1. It is 0 while `tx_en` is 0.
- R5: A byte written while the shifter is idle moves into the shifter on the next cycle. `hold_ready` is then 1 again, two cycles after the write strobe.
- R6: A byte written while the shifter is busy makes `hold_ready` 0 until the current frame ends. The byte then enters the shifter, `hold_ready` returns to 1, and that byte is the next frame sent.
- R7: A write while `hold_ready` is 0 is ignored. The byte already waiting is kept and sent, and no extra frame appears.
- R8: `all_sent` becomes 1 at the end of the stop bit of a frame when no byte is waiting. It returns to 0 when a byte is accepted, and is never 1 while a frame is in flight or a byte is waiting.
- R9: Setting `tx_en` to 0 discards both the waiting byte and the frame in progress. The next cycle, `ser_out` is 1 and `all_sent` and `hold_ready` are 0. After re-enabling, `hold_ready` is 1, nothing from before is sent, and `all_sent` stays 0 until a new frame has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; 0 clears the block |
| par_mode | input | 3 | Parity selection (codes in R3) |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_stb | input | 1 | Write strobe for the waiting slot |
| wr_data | input | 8 | Byte to send |
| ser_out | output | 1 | Serial line, idles high |
| hold_ready | output | 1 | Waiting slot can accept a byte |
| all_sent | output | 1 | Every accepted byte has fully left the line |

## Verification
Faults in the internal state show up at the ports. A wrong bit counter shows as a frame that is one bit too long or too short, within one frame time. A waiting byte that is lost or overwritten shows as a missing or altered next frame. A stuck slot-full state keeps `hold_ready` low past the end of the current frame. A stale flag shows one cycle after the stop bit or the disable, as `all_sent` rising early or late. The bench therefore compares every transmitted frame bit by bit at the middle of each bit period, and samples both flags at the exact cycles where they must change.

// File: rtl/uart_tx_pkg.sv
// Package: shared parity codes for the debug serial transmitter.
// Assumes: the 3-bit mode field carries one of these codes; other codes mean none.
package uart_tx_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_SPACE = 3'd3,
        PAR_MARK  = 3'd4
    } par_mode_e;

endpackage

// File: rtl/tx_parity_gen.sv
// Module: tx_parity_gen
// Does:    decides whether a parity bit is sent and computes its value from the data.
// Assumes: purely combinational; mode codes as in uart_tx_pkg, unknown codes act as none.
module tx_parity_gen
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        mode,
    output logic              has_par,
    output logic              par_bit
);

    logic ones_odd;
    assign ones_odd = ^data;

    // Map the mode code to parity presence and value.
    always_comb begin
        has_par = 1'b1;
        par_bit = 1'b1;
        case (par_mode_e'(mode))
            PAR_ODD:   par_bit = ~ones_odd;
            PAR_EVEN:  par_bit = ones_odd;
            PAR_SPACE: par_bit = 1'b0;
            PAR_MARK:  par_bit = 1'b1;
            default:   has_par = 1'b0;
        endcase
    end

endmodule

// File: rtl/tx_hold_reg.sv
// Module: tx_hold_reg
// Does:    one-byte waiting slot between the writer and the shifter.
// Assumes: take is only asserted while full; writes into a full slot are dropped.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic accept;
    assign accept = enable && wr_stb && !full;

    // Fill on an accepted write, empty when the shifter takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            full <= 1'b0;
            data <= '0;
        end else if (accept) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // A waiting byte stays put until the shifter takes it.
    p_keep_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && full && !take) |=> (full && $stable(data)));

endmodule

// File: rtl/tx_shifter.sv
// Module: tx_shifter
// Does:    serialises one frame (start, data LSB first, optional parity, stop),
//          advancing one bit on each baud tick.
// Assumes: load only while not busy; baud_tick is a single-cycle pulse.
module tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              has_par,
    input  logic              par_bit,
    output logic              busy,
    output logic              line,
    output logic              frame_done
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bits_left;

    assign frame_done = busy && baud_tick && (bits_left == '0);

    // Load a frame, then emit one bit per tick; the tick after the stop bit frees the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy      <= 1'b0;
            line      <= 1'b1;
            frame     <= '1;
            bits_left <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            frame     <= {1'b1, (has_par ? par_bit : 1'b1), load_data, 1'b0};
            bits_left <= has_par ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        end else if (busy && baud_tick) begin
            if (bits_left == '0) begin
                busy <= 1'b0;
                line <= 1'b1;
            end else begin
                line      <= frame[0];
                frame     <= {1'b1, frame[FRAME_W-1:1]};
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    // Line is high whenever no frame is in flight.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
    // Start bit waits for a tick: the line is still high in the cycle the frame is loaded.
    p_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> line);
    // Bit counter never exceeds the longest frame.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bits_left <= CNT_W'(FRAME_W));

endmodule

// File: rtl/dbg_uart_tx.sv
// Module: dbg_uart_tx
// Does:    double-buffered serial transmitter: waiting slot, parity generator, frame shifter,
//          and the slot-ready and all-sent flags.
// Assumes: baud_tick comes from an external divider; synchronous active-low reset.
module dbg_uart_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [2:0]        par_mode,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ser_out,
    output logic              hold_ready,
    output logic              all_sent
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_busy;
    logic              sh_done;
    logic              move;
    logic              has_par;
    logic              par_bit;
    logic              wr_accept;

    assign move       = hold_full && !sh_busy;
    assign hold_ready = tx_en && !hold_full;
    assign wr_accept  = hold_ready && wr_stb;

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tx_en),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (move),
        .full    (hold_full),
        .data    (hold_data)
    );

    tx_parity_gen #(.DATA_W(DATA_W)) u_par (
        .data    (hold_data),
        .mode    (par_mode),
        .has_par (has_par),
        .par_bit (par_bit)
    );

    tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_en),
        .baud_tick  (baud_tick),
        .load       (move),
        .load_data  (hold_data),
        .has_par    (has_par),
        .par_bit    (par_bit),
        .busy       (sh_busy),
        .line       (ser_out),
        .frame_done (sh_done)
    );

    // All-sent flag: set when the last stop bit ends with nothing waiting, cleared by a new byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            all_sent <= 1'b0;
        end else if (wr_accept) begin
            all_sent <= 1'b0;
        end else if (sh_done && !hold_full) begin
            all_sent <= 1'b1;
        end
    end

    // Slot-ready implies the transmitter is enabled.
    p_ready_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ready |-> tx_en);
    // All-sent only while both the slot and the shifter are empty.
    p_sent_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent |-> (!sh_busy && !hold_full));
    // Disabling parks the line high and clears the all-sent flag.
    p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (ser_out && !all_sent));

endmodule

// File: tb/dbg_uart_tx_test.sv
// Bench: directed scenarios for dbg_uart_tx, one task per scenario, each checking its own results.
module dbg_uart_tx_test;

    localparam int TICK_DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick;
    logic       ser_out;
    logic       hold_ready;
    logic       all_sent;

    int tests = 0;
    int fails = 0;
    logic [3:0] tick_cnt = 4'd0;

    always #10 clk = ~clk;

    // Free-running baud tick generator, one pulse every TICK_DIV cycles.
    always @(posedge clk) tick_cnt <= (tick_cnt == 4'(TICK_DIV - 1)) ? 4'd0 : tick_cnt + 4'd1;
    assign baud_tick = (tick_cnt == 4'(TICK_DIV - 1));

    dbg_uart_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .par_mode   (par_mode),
        .baud_tick  (baud_tick),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .ser_out    (ser_out),
        .hold_ready (hold_ready),
        .all_sent   (all_sent)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected frame from the requirements (R2, R3).
    function automatic void exp_frame(input logic [2:0] mode, input logic [7:0] d,
                                      output logic [10:0] f, output int n);
        logic p;
        logic use_p;
        use_p = 1'b1;
        p = 1'b1;
        case (mode)
            3'd1: p = ~(^d);
            3'd2: p = ^d;
            3'd3: p = 1'b0;
            3'd4: p = 1'b1;
            default: use_p = 1'b0;
        endcase
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[1+i] = d[i];
        if (use_p) begin
            f[9] = p;
            n = 11;
        end else begin
            f[9] = 1'b1;
            n = 10;
        end
    endfunction

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // Wait for a start bit, then sample every bit at its middle; leaves the bench at the stop-bit middle.
    task automatic get_frame(input int n, output logic [10:0] f, output logic ok);
        int waited;
        waited = 0;
        f = '1;
        ok = 1'b1;
        @(negedge clk);
        while (ser_out !== 1'b0 && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 400) begin
            ok = 1'b0;
        end else begin
            repeat (TICK_DIV / 2) @(negedge clk);
            f[0] = ser_out;
            for (int i = 1; i < n; i++) begin
                repeat (TICK_DIV) @(negedge clk);
                f[i] = ser_out;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line high after reset", 32'(ser_out), 32'd1);
        chk("R4 ready low while disabled", 32'(hold_ready), 32'd0);
        chk("R8 all_sent low after reset", 32'(all_sent), 32'd0);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R4 ready high once enabled", 32'(hold_ready), 32'd1);
        chk("R8 all_sent low before any frame", 32'(all_sent), 32'd0);
        chk("R1 line idle high while enabled", 32'(ser_out), 32'd1);
    endtask

    // One frame with a given parity mode and byte.
    task automatic t_frame(input logic [2:0] mode, input logic [7:0] d);
        logic [10:0] f;
        logic [10:0] e;
        int n;
        logic ok;
        par_mode = mode;
        exp_frame(mode, d, e, n);
        write_byte(d);
        @(negedge clk);
        chk("R5 ready back two cycles after write", 32'(hold_ready), 32'd1);
        chk("R8 all_sent low while frame pending", 32'(all_sent), 32'd0);
        get_frame(n, f, ok);
        chk("R2 frame seen", 32'(ok), 32'd1);
        chk($sformatf("R2/R3 frame mode %0d data %02h", mode, d), 32'(f), 32'(e));
        repeat (3) @(negedge clk);
        chk("R8 all_sent not before stop ends", 32'(all_sent), 32'd0);
        @(negedge clk);
        chk("R8 all_sent at stop end", 32'(all_sent), 32'd1);
        chk("R1 line high after frame", 32'(ser_out), 32'd1);
    endtask

    // Second byte while busy, a third write dropped.
    task automatic t_back_to_back();
        logic [10:0] f;
        logic [10:0] e;
        int n;
        logic ok;
        par_mode = 3'd2;
        write_byte(8'h5A);
        @(negedge clk);
        chk("R5 ready after first byte moves", 32'(hold_ready), 32'd1);
        write_byte(8'hC3);
        chk("R6 ready low with byte waiting", 32'(hold_ready), 32'd0);
        write_byte(8'h7E);
        chk("R7 ready still low after dropped write", 32'(hold_ready), 32'd0);
        exp_frame(3'd2, 8'h5A, e, n);
        get_frame(n, f, ok);
        chk("R6 first frame", 32'(f), 32'(e));
        chk("R6 ready low at first stop", 32'(hold_ready), 32'd0);
        repeat (6) @(negedge clk);
        chk("R6 ready back after handover", 32'(hold_ready), 32'd1);
        chk("R8 all_sent low with next frame pending", 32'(all_sent), 32'd0);
        exp_frame(3'd2, 8'hC3, e, n);
        get_frame(n, f, ok);
        chk("R6/R7 waiting byte kept and sent", 32'(f), 32'(e));
        repeat (4) @(negedge clk);
        chk("R8 all_sent after last frame", 32'(all_sent), 32'd1);
        begin
            logic low_seen;
            low_seen = 1'b0;
            repeat (200) begin
                @(negedge clk);
                if (ser_out !== 1'b1) low_seen = 1'b1;
            end
            chk("R7 no extra frame from dropped write", 32'(low_seen), 32'd0);
        end
    endtask

    // Disable in mid-frame with a byte waiting.
    task automatic t_disable();
        logic [10:0] f;
        logic [10:0] e;
        int n;
        logic ok;
        logic low_seen;
        par_mode = 3'd0;
        write_byte(8'h00);
        write_byte(8'hFF);
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R9 line high after disable", 32'(ser_out), 32'd1);
        chk("R9 ready low while disabled", 32'(hold_ready), 32'd0);
        chk("R9 all_sent low while disabled", 32'(all_sent), 32'd0);
        write_byte(8'h11);
        chk("R9 write while disabled not taken", 32'(hold_ready), 32'd0);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R9 ready high after re-enable", 32'(hold_ready), 32'd1);
        low_seen = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (ser_out !== 1'b1) low_seen = 1'b1;
        end
        chk("R9 nothing old sent after re-enable", 32'(low_seen), 32'd0);
        chk("R9 all_sent stays low until a frame", 32'(all_sent), 32'd0);
        exp_frame(3'd0, 8'h96, e, n);
        write_byte(8'h96);
        get_frame(n, f, ok);
        chk("R9 frame after re-enable", 32'(f), 32'(e));
        repeat (4) @(negedge clk);
        chk("R9 all_sent after new frame", 32'(all_sent), 32'd1);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_frame(3'd0, 8'hA5);
        t_frame(3'd1, 8'hA5);
        t_frame(3'd1, 8'h01);
        t_frame(3'd2, 8'h3C);
        t_frame(3'd2, 8'h07);
        t_frame(3'd3, 8'hFF);
        t_frame(3'd4, 8'h00);
        t_frame(3'd7, 8'h81);
        t_back_to_back();
        t_disable();
        report();
        $finish;
    end

endmodule